// File: doc/BRIEF.md
# USB Device Interrupt Status Controller

This block gathers the global interrupt sources of a USB device controller into one 32-bit status word that software reads. Seven bus events are held as sticky flags: suspend, micro start-of-frame, start-of-frame, end of bus reset, wakeup, end of resume and upstream resume. Each flag stays set until software writes a one to the matching bit of the acknowledge port. Endpoint and DMA channel requests are not stored. Each one shows the present level of its source.

The block also holds two counters. One is the 11-bit frame number, loaded from the received start-of-frame packet. The other is the 3-bit microframe number, which steps on each high-speed micro start-of-frame. A timer measures how long the bus has been idle and raises suspend once the idle time reaches a limit, which is a parameter. A registered interrupt line goes high when any status bit is set and its bit in the enable mask is one.

Top module: `usb_dev_irq_status`

## Requirements
- R1: Reset leaves the status word all zero. Bits 7..11 and 22..24 always read zero. The event flags sit at these positions: suspend 0, micro-SOF 1, SOF 2, end-of-reset 3, wakeup 4, end-of-resume 5, upstream-resume 6.
- R2: Each of bits 0..6 becomes one in the status word on the clock edge that follows its event. It stays one until a cycle in which bit n of `ack` is one, and it reads zero after that edge.
- R3: When wakeup sets, suspend clears, and when suspend sets, wakeup clears. If both would set in the same cycle, wakeup is set and suspend is cleared. An upstream-resume event does not set wakeup.
- R4: Suspend sets after `line_idle` has been high for SUSP_CYCLES cycles in a row. The timer fires only once in each idle period. A low cycle on `line_idle` restarts it.
- R5: In high-speed mode (`hs_mode`=1), a micro-SOF event sets bit 1 and adds one to `uframe_num`, wrapping from 7 to 0. `frame_num` does not change. In full-speed mode a micro-SOF event is ignored.
- R6: A SOF event sets bit 2 and loads `frame_num` from `sof_frame`. In high-speed mode it also clears `uframe_num`, and this takes priority over a micro-SOF in the same cycle. In full-speed mode `uframe_num` is left as it is.
- R7: Bits 12..21 show `ep_req[9:0]` and bits 25..31 show `dma_req[6:0]` in the same cycle, with no storage.
- R8: If a flag's set event and its acknowledge arrive in the same cycle, the flag ends up set.
- R9: `irq` is registered. In each cycle it equals the OR over all bits of (status AND `mask`) from the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hs_mode | input | 1 | 1 = high-speed operation |
| line_idle | input | 1 | Bus is in the idle J state |
| ev_msof | input | 1 | Micro start-of-frame received (pulse) |
| ev_sof | input | 1 | Start-of-frame received (pulse) |
| sof_frame | input | 11 | Frame field of the received SOF packet |
| ev_eorst | input | 1 | End of bus reset (pulse) |
| ev_wake | input | 1 | Filtered non-idle line activity (pulse) |
| ev_eorsm | input | 1 | End of host resume (pulse) |
| ev_uprsm | input | 1 | Upstream resume sent (pulse) |
| ep_req | input | 10 | Endpoint interrupt request levels |
| dma_req | input | 7 | DMA channel interrupt request levels |
| ack | input | 32 | Write-one-to-clear acknowledge word |
| mask | input | 32 | Interrupt enable mask |
| status | output | 32 | Interrupt status word |
| irq | output | 1 | Combined interrupt request |
| frame_num | output | 11 | Current frame number |
| uframe_num | output | 3 | Current microframe number |

## Verification
The bench holds the bus idle for exactly one cycle fewer than the limit, and then for exactly the limit. A timer that is off by one flags suspend too early or too late. It then keeps the bus idle well past the limit after an acknowledge. A timer that fires again in the same idle period would set suspend a second time. Wakeup and suspend are driven into each other, including wakeup and a suspend expiry on the same edge, to catch a missing cross-clear or the wrong winner. Set and acknowledge are applied together on one flag, where a design that lets acknowledge win would lose the event. Micro-SOF is run past seven to check the wrap, and SOF is sent in both speed modes to check that the microframe is cleared only in high-speed mode. A random phase compares the status word, the counters and the one-cycle lag of `irq` with the reference model on every clock.

// File: rtl/usbirq_pkg.sv
package usbirq_pkg;
  localparam int unsigned STAT_W   = 32;
  localparam int unsigned N_EVT    = 7;
  localparam int unsigned N_EP     = 10;
  localparam int unsigned EP_LSB   = 12;
  localparam int unsigned N_DMA    = 7;
  localparam int unsigned DMA_LSB  = 25;
  localparam int unsigned FRAME_W  = 11;
  localparam int unsigned UFRAME_W = 3;

  typedef enum int unsigned {
    EV_SUSP  = 0,
    EV_MSOF  = 1,
    EV_SOF   = 2,
    EV_EORST = 3,
    EV_WAKE  = 4,
    EV_EORSM = 5,
    EV_UPRSM = 6
  } evt_idx_e;

  typedef logic [N_EVT-1:0] evt_vec_t;
endpackage

// File: rtl/usbirq_idle_timer.sv
module usbirq_idle_timer #(
  parameter int unsigned SUSP_CYCLES = 90000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_idle,
  output logic fire
);
  localparam int unsigned CW = $clog2(SUSP_CYCLES + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          done_q, done_d;
  logic          en;

  always_comb begin
    cnt_d  = cnt_q;
    done_d = done_q;
    fire   = 1'b0;
    if (!line_idle) begin
      cnt_d  = '0;
      done_d = 1'b0;
    end else if (!done_q) begin
      if (cnt_q == CW'(SUSP_CYCLES - 1)) begin
        fire   = 1'b1;
        done_d = 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  assign en = (cnt_d != cnt_q) || (done_d != done_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (en) begin
      cnt_q  <= cnt_d;
      done_q <= done_d;
    end
  end
endmodule

// File: rtl/usbirq_sticky.sv
module usbirq_sticky (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic ack_i,
  input  logic xclr_i,
  output logic flag_o
);
  logic flag_q, flag_d, en;

  always_comb begin
    flag_d = set_i | (flag_q & ~ack_i & ~xclr_i);
    en     = set_i | ack_i | xclr_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  flag_q <= 1'b0;
    else if (en) flag_q <= flag_d;
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/usbirq_frame_ctr.sv
module usbirq_frame_ctr #(
  parameter int unsigned FRAME_W  = 11,
  parameter int unsigned UFRAME_W = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                hs_mode,
  input  logic                ev_sof,
  input  logic                ev_msof,
  input  logic [FRAME_W-1:0]  sof_frame,
  output logic [FRAME_W-1:0]  frame_num,
  output logic [UFRAME_W-1:0] uframe_num
);
  logic [FRAME_W-1:0]  frame_q;
  logic [UFRAME_W-1:0] uframe_q, uframe_d;
  logic                uframe_en;

  always_comb begin
    uframe_d  = uframe_q;
    uframe_en = 1'b0;
    if (ev_sof && hs_mode) begin
      uframe_d  = '0;
      uframe_en = 1'b1;
    end else if (ev_msof && hs_mode) begin
      uframe_d  = uframe_q + 1'b1;
      uframe_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      frame_q <= '0;
    else if (ev_sof) frame_q <= sof_frame;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         uframe_q <= '0;
    else if (uframe_en) uframe_q <= uframe_d;
  end

  assign frame_num  = frame_q;
  assign uframe_num = uframe_q;
endmodule

// File: rtl/usb_dev_irq_status.sv
module usb_dev_irq_status
  import usbirq_pkg::*;
#(
  parameter int unsigned SUSP_CYCLES = 90000
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                hs_mode,
  input  logic                line_idle,
  input  logic                ev_msof,
  input  logic                ev_sof,
  input  logic [FRAME_W-1:0]  sof_frame,
  input  logic                ev_eorst,
  input  logic                ev_wake,
  input  logic                ev_eorsm,
  input  logic                ev_uprsm,
  input  logic [N_EP-1:0]     ep_req,
  input  logic [N_DMA-1:0]    dma_req,
  input  logic [STAT_W-1:0]   ack,
  input  logic [STAT_W-1:0]   mask,
  output logic [STAT_W-1:0]   status,
  output logic                irq,
  output logic [FRAME_W-1:0]  frame_num,
  output logic [UFRAME_W-1:0] uframe_num
);
  logic     idle_fire;
  logic     susp_set;
  evt_vec_t set_v, xclr_v, flags;
  logic     irq_q, irq_d;

  usbirq_idle_timer #(.SUSP_CYCLES(SUSP_CYCLES)) u_idle (
    .clk       (clk),
    .rst_n     (rst_n),
    .line_idle (line_idle),
    .fire      (idle_fire)
  );

  usbirq_frame_ctr #(.FRAME_W(FRAME_W), .UFRAME_W(UFRAME_W)) u_frame (
    .clk        (clk),
    .rst_n      (rst_n),
    .hs_mode    (hs_mode),
    .ev_sof     (ev_sof),
    .ev_msof    (ev_msof),
    .sof_frame  (sof_frame),
    .frame_num  (frame_num),
    .uframe_num (uframe_num)
  );

  // wakeup has priority over a same-cycle suspend expiry
  assign susp_set = idle_fire & ~ev_wake;

  always_comb begin
    set_v           = '0;
    set_v[EV_SUSP]  = susp_set;
    set_v[EV_MSOF]  = ev_msof & hs_mode;
    set_v[EV_SOF]   = ev_sof;
    set_v[EV_EORST] = ev_eorst;
    set_v[EV_WAKE]  = ev_wake;
    set_v[EV_EORSM] = ev_eorsm;
    set_v[EV_UPRSM] = ev_uprsm;
    xclr_v          = '0;
    xclr_v[EV_SUSP] = ev_wake;
    xclr_v[EV_WAKE] = susp_set;
  end

  for (genvar i = 0; i < N_EVT; i++) begin : g_flag
    usbirq_sticky u_flag (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (set_v[i]),
      .ack_i  (ack[i]),
      .xclr_i (xclr_v[i]),
      .flag_o (flags[i])
    );
  end

  always_comb begin
    status                          = '0;
    status[N_EVT-1:0]               = flags;
    status[EP_LSB +: N_EP]          = ep_req;
    status[DMA_LSB +: N_DMA]        = dma_req;
  end

  assign irq_d = |(status & mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_d;
  end

  assign irq = irq_q;
endmodule

// File: rtl/usbirq_checker.sv
module usbirq_checker
  import usbirq_pkg::*;
(
  input logic                clk,
  input logic                rst_n,
  input logic                ev_msof,
  input logic                ev_sof,
  input logic                ev_eorst,
  input logic                ack_eorst,
  input logic [STAT_W-1:0]   status,
  input logic [STAT_W-1:0]   mask,
  input logic                irq,
  input logic [FRAME_W-1:0]  frame_num
);
  AST_WAKE_CLEARS_SUSP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[4]) |-> !status[0]);                               // R3
  AST_SUSP_CLEARS_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[0]) |-> !status[4]);                               // R3
  AST_EORST_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (status[3] && !ack_eorst) |=> status[3]);                       // R2
  AST_EORST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    ev_eorst |=> status[3]);                                        // R8
  AST_MSOF_FRAME_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_msof && !ev_sof) |=> $stable(frame_num));                   // R5
  AST_IRQ_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    (|(status & mask)) |=> irq);                                    // R9
  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !(|(status & mask)) |=> !irq);                                  // R9
  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    status[11:7] == '0 && status[24:22] == '0);                     // R1
endmodule

bind usb_dev_irq_status usbirq_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ev_msof   (ev_msof),
  .ev_sof    (ev_sof),
  .ev_eorst  (ev_eorst),
  .ack_eorst (ack[3]),
  .status    (status),
  .mask      (mask),
  .irq       (irq),
  .frame_num (frame_num)
);

// File: tb/usb_dev_irq_status_test.sv
module usb_dev_irq_status_test;
  localparam int NSUSP = 16;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        hs_mode, line_idle, ev_msof, ev_sof, ev_eorst, ev_wake, ev_eorsm, ev_uprsm;
  logic [10:0] sof_frame;
  logic [9:0]  ep_req;
  logic [6:0]  dma_req;
  logic [31:0] ack, mask, status;
  logic        irq;
  logic [10:0] frame_num;
  logic [2:0]  uframe_num;

  int tests = 0;
  int fails = 0;

  // reference model state
  bit [6:0] m_flag;
  int       m_frame, m_uframe, m_cnt;
  bit       m_done, m_irq;

  usb_dev_irq_status #(.SUSP_CYCLES(NSUSP)) uut (
    .clk(clk), .rst_n(rst_n), .hs_mode(hs_mode), .line_idle(line_idle),
    .ev_msof(ev_msof), .ev_sof(ev_sof), .sof_frame(sof_frame),
    .ev_eorst(ev_eorst), .ev_wake(ev_wake), .ev_eorsm(ev_eorsm), .ev_uprsm(ev_uprsm),
    .ep_req(ep_req), .dma_req(dma_req), .ack(ack), .mask(mask),
    .status(status), .irq(irq), .frame_num(frame_num), .uframe_num(uframe_num));

  always #5 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] m_status();
    logic [31:0] s = 32'h0;
    s[6:0]   = m_flag;
    s[21:12] = ep_req;
    s[31:25] = dma_req;
    return s;
  endfunction

  task automatic model_edge();
    bit fire, sset;
    bit [6:0] set;
    m_irq = (m_status() & mask) != 0;
    fire = 0;
    if (!line_idle) begin
      m_cnt = 0; m_done = 0;
    end else if (!m_done) begin
      m_cnt++;
      if (m_cnt >= NSUSP) begin fire = 1; m_done = 1; end
    end
    sset = fire && !ev_wake;
    set = {ev_uprsm, ev_eorsm, ev_wake, ev_eorst, ev_sof, ev_msof && hs_mode, sset};
    for (int b = 0; b < 7; b++)
      if (set[b]) m_flag[b] = 1'b1;
      else if (ack[b]) m_flag[b] = 1'b0;
    if (ev_wake) m_flag[0] = 1'b0;
    if (sset)    m_flag[4] = 1'b0;
    if (ev_sof) m_frame = sof_frame;
    if (ev_sof && hs_mode) m_uframe = 0;
    else if (ev_msof && hs_mode) m_uframe = (m_uframe + 1) % 8;
  endtask

  task automatic compare();
    logic [31:0] e = m_status();
    chk("R2 event flags", {25'h0, status[6:0]}, {25'h0, e[6:0]});
    chk("R7 live request bits", status & 32'hFE3F_F000, e & 32'hFE3F_F000);
    chk("R1 reserved bits", status & 32'h01C0_0F80, 32'h0);
    chk("R9 irq", {31'h0, irq}, {31'h0, m_irq});
    chk("R6 frame_num", {21'h0, frame_num}, m_frame);
    chk("R5 uframe_num", {29'h0, uframe_num}, m_uframe);
  endtask

  task automatic cyc();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare();
    ev_msof = 0; ev_sof = 0; ev_eorst = 0; ev_wake = 0; ev_eorsm = 0; ev_uprsm = 0;
    ack = '0;
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
  endtask

  initial begin
    #5_000_000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    rst_n = 0; hs_mode = 1; line_idle = 0; ev_msof = 0; ev_sof = 0; sof_frame = '0;
    ev_eorst = 0; ev_wake = 0; ev_eorsm = 0; ev_uprsm = 0; ep_req = '0; dma_req = '0;
    ack = '0; mask = '0;
    m_flag = '0; m_frame = 0; m_uframe = 0; m_cnt = 0; m_done = 0; m_irq = 0;
    repeat (3) @(negedge clk);
    chk("R1 reset status", status, 32'h0);
    chk("R9 reset irq", {31'h0, irq}, 32'h0);
    rst_n = 1;
    cyc();

    // R2: each sticky event, then acknowledge
    ev_eorst = 1; ev_eorsm = 1; ev_uprsm = 1; cyc();
    chk("R3 uprsm leaves wakeup clear", {31'h0, status[4]}, 32'h0);
    chk("R2 flags set", {25'h0, status[6:0]}, 32'h68);
    cyc();
    ack = 32'h0000_0068; cyc();
    chk("R2 flags cleared by ack", {25'h0, status[6:0]}, 32'h0);

    // R8: set and ack on the same edge
    ev_eorst = 1; ack = 32'h8; cyc();
    chk("R8 set wins over ack", {31'h0, status[3]}, 32'h1);
    ack = 32'h8; cyc();

    // R4: idle one short of the limit, then exactly the limit
    line_idle = 1; repeat (NSUSP - 1) cyc();
    chk("R4 no suspend early", {31'h0, status[0]}, 32'h0);
    line_idle = 0; cyc();
    line_idle = 1; repeat (NSUSP - 1) cyc();
    chk("R4 restart on non-idle", {31'h0, status[0]}, 32'h0);
    cyc();
    chk("R4 suspend at limit", {31'h0, status[0]}, 32'h1);
    ack = 32'h1; cyc();
    repeat (3 * NSUSP) cyc();
    chk("R4 single fire per idle period", {31'h0, status[0]}, 32'h0);
    // R3: wakeup clears suspend, suspend clears wakeup
    line_idle = 0; cyc();
    line_idle = 1; repeat (NSUSP) cyc();
    ev_wake = 1; cyc();
    chk("R3 wakeup clears suspend", {30'h0, status[4], status[0]}, 32'h2);
    line_idle = 0; cyc();
    line_idle = 1; repeat (NSUSP) cyc();
    chk("R3 suspend clears wakeup", {30'h0, status[4], status[0]}, 32'h1);
    line_idle = 0; cyc();
    line_idle = 1; repeat (NSUSP - 1) cyc();
    ev_wake = 1; cyc();
    chk("R3 wakeup wins same cycle", {30'h0, status[4], status[0]}, 32'h2);
    line_idle = 0; ack = 32'h11; cyc();

    // R5/R6: microframes and frames in both modes
    hs_mode = 1; ev_sof = 1; sof_frame = 11'h5A3; cyc();
    for (int k = 0; k < 9; k++) begin ev_msof = 1; cyc(); end
    chk("R5 uframe wraps", {29'h0, uframe_num}, 32'h1);
    chk("R5 frame unchanged", {21'h0, frame_num}, 32'h5A3);
    ev_sof = 1; ev_msof = 1; sof_frame = 11'h7FF; cyc();
    chk("R6 sof clears uframe", {29'h0, uframe_num}, 32'h0);
    ev_msof = 1; cyc();
    ack = 32'h6; cyc();
    hs_mode = 0; ev_msof = 1; cyc();
    chk("R5 msof ignored in full speed", {29'h0, status[1], uframe_num}, 32'h1);
    ev_sof = 1; sof_frame = 11'h012; cyc();
    chk("R6 full speed keeps uframe", {29'h0, uframe_num}, 32'h1);

    // R7/R9: live bits and masking
    ack = 32'h7F; cyc();
    ep_req = 10'h201; dma_req = 7'h41; #1;
    chk("R7 live bits same cycle", status, 32'h8220_1000);
    mask = 32'h0000_1000; cyc(); cyc();
    chk("R9 irq from masked endpoint", {31'h0, irq}, 32'h1);
    ep_req = '0; cyc(); cyc();
    chk("R9 irq drops after source serviced", {31'h0, irq}, 32'h0);
    dma_req = '0;

    // random phase
    for (int n = 0; n < 4000; n++) begin
      hs_mode   = ($urandom_range(0, 9) != 0);
      line_idle = ($urandom_range(0, 40) != 0);
      ev_msof   = ($urandom_range(0, 3) == 0);
      ev_sof    = ($urandom_range(0, 7) == 0);
      sof_frame = 11'($urandom);
      ev_eorst  = ($urandom_range(0, 9) == 0);
      ev_wake   = ($urandom_range(0, 30) == 0);
      ev_eorsm  = ($urandom_range(0, 9) == 0);
      ev_uprsm  = ($urandom_range(0, 9) == 0);
      ep_req    = 10'($urandom) & 10'($urandom);
      dma_req   = 7'($urandom) & 7'($urandom) & 7'($urandom);
      ack       = $urandom & $urandom;
      if ($urandom_range(0, 15) == 0) mask = $urandom & $urandom & $urandom;
      cyc();
    end

    summary();
    $finish;
  end
endmodule